// File: doc/BRIEF.md
# Destination Address Hash Filter

This block holds a small bit table indexed by a hash of 48-bit destination MAC addresses. It classifies received frames against that table. Software or a control engine installs and withdraws addresses through a one-cycle command port. The receive path presents each frame's destination address on a lookup port and gets back a hit flag a fixed two cycles later. Each 32-bit row of the table can be read back directly, and the block keeps a saturating count of installed entries.

The hash is a CRC-32 over the six address bytes. It is computed in the reflected form, inverted, and mirrored across all 32 bits. The hash is shifted right so that only enough upper bits remain to address the table. The parameter `TABLE_BITS` chooses a table of 64, 128 or 256 bits, or 0 to turn hashing off. The CRC is unrolled into combinational logic and registered once. A second register stage either writes the table or reads it.

Top module: `mac_hash_filter`

## Requirements
- R1: The hash is computed over the address bits in this order: byte k is `addr[8k+7:8k]` for k = 0 to 5, and each byte is fed LSB first. The CRC uses the reflected polynomial 0xEDB88320 and starts from all ones. The final remainder is inverted and then bit-reversed across 32 bits.
- R2: The index is the hash shifted right by 26 − TABLE_BITS/128. In that index, bits [4:0] select the bit within a row and the bits above select the 32-bit row. Row r occupies table bits 32r+31 down to 32r.
- R3: An add command (`cmd_valid` with `cmd_add`=1) sets the indexed bit. The bit is visible on `rd_data` from the second clock edge after the command is sampled.
- R4: A remove command (`cmd_valid` with `cmd_add`=0) clears the indexed bit with the same timing as an add.
- R5: A command changes at most one bit of the table. With no command, the table holds its value.
- R6: An add raises `entry_count` by one and a remove lowers it by one, with the same timing as the table write. Adding an address that is already present still counts.
- R7: `entry_count` stays at its maximum when an add arrives at the maximum, and stays at zero when a remove arrives at zero. It never wraps.
- R8: A lookup sampled at one edge gives `lk_done`=1 after the second following edge. `lk_hit` then equals the indexed table bit.
- R9: When a lookup and a command are sampled on the same edge, the lookup sees the table as it was before that command. A lookup sampled one edge later sees the command's effect.
- R10: Reset clears the whole table, `entry_count`, `lk_done` and `lk_hit`.
- R11: With TABLE_BITS = 0, `lk_hit`, `rd_data` and `entry_count` stay 0 whatever commands arrive. `lk_done` keeps its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_add | input | 1 | 1 = install address, 0 = withdraw address |
| cmd_addr | input | 48 | Address for the command, byte 0 in bits [7:0] |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to classify, byte 0 in bits [7:0] |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Indexed table bit for the finished lookup |
| rd_row | input | ROW_W | Row selected for readback |
| rd_data | output | 32 | Current contents of the selected row |
| entry_count | output | COUNT_W | Saturating count of installed entries |

## Verification
A table update and a lookup can fall in the same cycle. An add for an address whose bit is still clear is issued on the same edge as a lookup of that address. The scoreboard expects the pre-add value 0. A further lookup one cycle later must return 1. The count is also driven past both of its limits with a narrow counter, and a second instance with hashing turned off takes the same stimulus.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam logic [31:0] MHF_POLY_REFL = 32'hEDB8_8320;

  // Reflected CRC-32 over six address bytes, byte 0 first, LSB first.
  function automatic logic [31:0] mhf_crc_refl(input logic [47:0] addr);
    logic [31:0] c;
    c = '1;
    for (int k = 0; k < 6; k++) begin
      c = c ^ {24'd0, addr[8*k +: 8]};
      for (int b = 0; b < 8; b++) begin
        c = (c >> 1) ^ (c[0] ? MHF_POLY_REFL : 32'd0);
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] mhf_rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] mhf_hash(input logic [47:0] addr);
    return mhf_rev32(~mhf_crc_refl(addr));
  endfunction

  function automatic int mhf_shift(input int tbits);
    return 26 - tbits / 128;
  endfunction

  function automatic int mhf_row_w(input int tbits);
    return (tbits / 32 > 1) ? $clog2(tbits / 32) : 1;
  endfunction

endpackage

// File: rtl/mhf_hash_stage.sv
module mhf_hash_stage
  import mhf_pkg::*;
#(
  parameter int TABLE_BITS = 64,
  parameter int ROW_W      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [47:0]      in_addr,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row,
  output logic [4:0]       out_bit
);
  localparam int IDX_W = 5 + ROW_W;
  localparam int SHIFT = mhf_shift(TABLE_BITS);

  logic [31:0]      hash_now;
  logic [IDX_W-1:0] idx_now;

  assign hash_now = mhf_hash(in_addr);
  assign idx_now  = IDX_W'(hash_now >> SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_bit   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_row <= idx_now[IDX_W-1:5];
        out_bit <= idx_now[4:0];
      end
    end
  end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int TABLE_BITS = 64,
  parameter int ROW_W      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_set,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [4:0]       wr_bit,
  input  logic             lk_en,
  input  logic [ROW_W-1:0] lk_row,
  input  logic [4:0]       lk_bit,
  output logic             lk_done,
  output logic             lk_hit,
  input  logic [ROW_W-1:0] rd_row,
  output logic [31:0]      rd_data
);
  logic [TABLE_BITS-1:0] tbl;
  logic [ROW_W+4:0]      wr_pos;
  logic [ROW_W+4:0]      lk_pos;

  assign wr_pos  = {wr_row, wr_bit};
  assign lk_pos  = {lk_row, lk_bit};
  assign rd_data = tbl[{rd_row, 5'd0} +: 32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl     <= '0;
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
    end else begin
      lk_done <= lk_en;
      lk_hit  <= lk_en & tbl[lk_pos];
      if (wr_en) tbl[wr_pos] <= wr_set;
    end
  end

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_set) |=> tbl[$past(wr_pos)]);

  assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_set) |=> !tbl[$past(wr_pos)]);

  assert_one_bit_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tbl ^ $past(tbl)) <= 1);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tbl));

endmodule

// File: rtl/mhf_entry_count.sv
module mhf_entry_count #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  output logic [COUNT_W-1:0] count
);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  logic at_zero;

  assign at_max  = (count == CNT_MAX);
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && !at_max) begin
      count <= count + 1'b1;
    end else if (dec && !at_zero) begin
      count <= count - 1'b1;
    end
  end

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_max) |=> count == $past(count) + 1'b1);

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !at_zero) |=> count == $past(count) - 1'b1);

  assert_no_wrap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_max) |=> count == CNT_MAX);

  assert_no_wrap_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && at_zero) |=> count == '0);

endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mhf_pkg::*;
#(
  parameter  int TABLE_BITS = 64,
  parameter  int COUNT_W    = 8,
  localparam int ROW_W      = mhf_row_w(TABLE_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_add,
  input  logic [47:0]        cmd_addr,
  input  logic               lk_valid,
  input  logic [47:0]        lk_addr,
  output logic               lk_done,
  output logic               lk_hit,
  input  logic [ROW_W-1:0]   rd_row,
  output logic [31:0]        rd_data,
  output logic [COUNT_W-1:0] entry_count
);
  logic             cmd_q_valid;
  logic             cmd_q_add;
  logic [ROW_W-1:0] cmd_q_row;
  logic [4:0]       cmd_q_bit;
  logic             lk_q_valid;
  logic [ROW_W-1:0] lk_q_row;
  logic [4:0]       lk_q_bit;
  logic             ev_install;
  logic             ev_withdraw;

  mhf_hash_stage #(.TABLE_BITS(TABLE_BITS), .ROW_W(ROW_W)) u_cmd_hash (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_addr(cmd_addr),
    .out_valid(cmd_q_valid), .out_row(cmd_q_row), .out_bit(cmd_q_bit)
  );

  mhf_hash_stage #(.TABLE_BITS(TABLE_BITS), .ROW_W(ROW_W)) u_lk_hash (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_addr(lk_addr),
    .out_valid(lk_q_valid), .out_row(lk_q_row), .out_bit(lk_q_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_q_add <= 1'b0;
    else if (cmd_valid) cmd_q_add <= cmd_add;
  end

  assign ev_install  = (TABLE_BITS != 0) && cmd_q_valid && cmd_q_add;
  assign ev_withdraw = (TABLE_BITS != 0) && cmd_q_valid && !cmd_q_add;

  mhf_entry_count #(.COUNT_W(COUNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(ev_install), .dec(ev_withdraw),
    .count(entry_count)
  );

  generate
    if (TABLE_BITS == 0) begin : g_off
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= lk_q_valid;
      end
      assign lk_done = done_q;
      assign lk_hit  = 1'b0;
      assign rd_data = '0;

      assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit && rd_data == '0 && entry_count == '0);
    end else begin : g_on
      mhf_table #(.TABLE_BITS(TABLE_BITS), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_q_valid), .wr_set(cmd_q_add),
        .wr_row(cmd_q_row), .wr_bit(cmd_q_bit),
        .lk_en(lk_q_valid), .lk_row(lk_q_row), .lk_bit(lk_q_bit),
        .lk_done(lk_done), .lk_hit(lk_hit),
        .rd_row(rd_row), .rd_data(rd_data)
      );
    end
  endgenerate

  assert_lookup_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 lk_done);

  assert_hit_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_done);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (entry_count == '0 && !lk_done && !lk_hit));

endmodule

// File: tb/sim_mac_hash_filter.sv
module sim_mac_hash_filter;
  localparam int TB = 64;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_add = 1'b0;
  logic [47:0] cmd_addr = '0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        rd_row = 1'b0;
  logic        lk_done, lk_hit, off_done, off_hit;
  logic [31:0] rd_data, off_rd;
  logic [CW-1:0] entry_count;
  logic [7:0]  off_cnt;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  logic [TB-1:0] mtab = '0;
  int mcnt = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  mac_hash_filter #(.TABLE_BITS(TB), .COUNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_add(cmd_add),
    .cmd_addr(cmd_addr), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .rd_row(rd_row), .rd_data(rd_data),
    .entry_count(entry_count)
  );

  mac_hash_filter #(.TABLE_BITS(0), .COUNT_W(8)) u_off (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_add(cmd_add),
    .cmd_addr(cmd_addr), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(off_done), .lk_hit(off_hit), .rd_row(rd_row), .rd_data(off_rd),
    .entry_count(off_cnt)
  );

  // Non-reflected, MSB-first form of the same CRC over the 48-bit stream.
  function automatic int model_idx(input logic [47:0] a);
    logic [31:0] r;
    logic fb;
    r = '1;
    for (int i = 0; i < 48; i++) begin
      fb = r[31] ^ a[i];
      r  = {r[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'd0);
    end
    return int'((~r) >> (26 - TB / 128)) & (TB - 1);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_cmd(input bit add, input logic [47:0] a);
    mtab[model_idx(a)] = add;
    if (add && mcnt < CMAX) mcnt++;
    if (!add && mcnt > 0) mcnt--;
  endtask

  task automatic do_cmd(input bit add, input logic [47:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_add = add; cmd_addr = a;
    model_cmd(add, a);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [47:0] a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(mtab[model_idx(a)]); tag_q.push_back(tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic check_state(input string tag);
    repeat (3) @(negedge clk);
    for (int r = 0; r < TB / 32; r++) begin
      rd_row = r[0];
      #1;
      check({tag, " row"}, rd_data, mtab[32*r +: 32]);
      check("R11 off row", off_rd, 0);
    end
    check({tag, " count R6"}, entry_count, mcnt);
    check("R11 off count", off_cnt, 0);
  endtask

  // Monitor: pops expected lookup results as the design delivers them.
  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected lk_done", 1, 0);
      end else begin
        check(tag_q.pop_front(), lk_hit, exp_q.pop_front());
      end
    end
    if (rst_n && off_done) check("R11 off hit", off_hit, 0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [47:0] addrs[5];
    logic [47:0] fresh;
    addrs[0] = 48'h0000_0000_0000;
    addrs[1] = 48'hFFFF_FFFF_FFFF;
    addrs[2] = 48'h0100_00C2_8001;
    addrs[3] = 48'h0605_0403_0201;
    addrs[4] = 48'h5E00_0001_005E;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 lk_done", lk_done, 0);
    check("R10 count", entry_count, 0);
    rd_row = 1'b0; #1 check("R10 row0", rd_data, 0);
    rd_row = 1'b1; #1 check("R10 row1", rd_data, 0);
    rst_n = 1'b1;
    check_state("R10 after release");

    // R1 R2 R3: installs land on the independently computed bit
    foreach (addrs[i]) begin
      do_cmd(1'b1, addrs[i]);
      check_state("R1 R2 R3 add");
    end
    // R8: lookups of installed and unknown addresses
    foreach (addrs[i]) do_lookup(addrs[i], "R8 lookup installed");
    do_lookup(48'h1234_5678_9ABC, "R8 lookup other");
    do_lookup(48'h0000_0000_0080, "R8 lookup other");

    // R4 R5: withdraw one address
    do_cmd(1'b0, addrs[2]);
    check_state("R4 R5 remove");
    do_lookup(addrs[2], "R4 lookup after remove");

    // R9: add and lookup in the same cycle, then one cycle later
    fresh = 48'h00AA_0000_0000;
    while (mtab[model_idx(fresh)]) fresh = fresh + 48'd1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_add = 1'b1; cmd_addr = fresh;
    lk_valid = 1'b1; lk_addr = fresh;
    exp_q.push_back(1'b0); tag_q.push_back("R9 same-cycle lookup");
    model_cmd(1'b1, fresh);
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_q.push_back(1'b1); tag_q.push_back("R9 next-cycle lookup");
    @(negedge clk);
    lk_valid = 1'b0;
    check_state("R9 after add");

    // R7: saturate at the top, then at zero
    repeat (20) do_cmd(1'b1, addrs[3]);
    check_state("R7 top");
    check("R7 count max", entry_count, CMAX);
    repeat (20) do_cmd(1'b0, addrs[3]);
    check_state("R7 bottom");
    check("R7 count zero", entry_count, 0);
    do_cmd(1'b1, addrs[0]);
    check_state("R7 recount");

    repeat (6) @(negedge clk);
    check("R8 pending lookups", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule